// File: doc/BRIEF.md
# Store Buffer with Byte-Merge Forwarding

This block queues a core's stores between the execution side and a simple memory port. Each store carries a doubleword address, a per-lane byte mask and 64 bits of data. It enters a circular queue and leaves it in strict arrival order. The head entry is written to memory only in a cycle where the memory side reports that it holds the target line in a writable state. Until that write happens, no other observer can see the store.

Loads of up to eight bytes are answered in the same cycle. The block reads the memory data for the load's doubleword and then places, lane by lane, the bytes of any queued stores to that doubleword over it. When several queued stores cover a lane, the youngest one wins. A load that is wider than a queued store still completes this way, and the store stays queued. Such a load is therefore ordered ahead of that store, which is how store-then-load reordering becomes visible to software.

A fence request and a locked-operation request both hold back every load and store until the queue is empty. Each is then acknowledged. If the queue is already empty, the acknowledgement comes in the same cycle.

Top module: `stbuf_top`

## Requirements
- R1: A queued store is written to memory only in a cycle where `mem_own_i` is high. While ownership is withheld the store stays queued, `mem_wr_req_o` stays high and the memory content is unchanged.
- R2: A load whose doubleword address and lane mask equal those of a queued store returns that store's data in the same cycle, with `ld_fwd_o` equal to `ld_be_i`.
- R3: A load that only partly overlaps queued stores returns the queued bytes laid over `mem_rd_data_i`. Byte lane b is bits 8b+7:8b and is selected by mask bit b. The stores stay queued and memory stays unchanged.
- R4: When more than one queued store to the load's doubleword enables the same lane, the load takes that lane from the most recently accepted store.
- R5: `st_ready_o` is low while DEPTH entries are queued, and a store offered in that state is not accepted.
- R6: While `fence_i` is high and the queue is not empty, `fence_done_o`, `st_ready_o` and `ld_ready_o` are low. `fence_done_o` rises once the last entry has committed.
- R7: A fence raised while the queue is empty gets `fence_done_o` high in the same cycle.
- R8: `lock_i` behaves like a fence. `lock_go_o` stays low until the queue is empty, and loads and stores are held meanwhile.
- R9: With ownership granted, entries commit in the order they were accepted, at one per cycle.
- R10: A load with no matching queued bytes returns `mem_rd_data_i` on its enabled lanes, and `ld_fwd_o` is zero.
- R11: Lanes not enabled by `ld_be_i` read as zero on `ld_data_o`, and `ld_fwd_o` never sets a lane outside `ld_be_i`.
- R12: After reset the queue is empty: `mem_wr_req_o` is low, and `st_ready_o` and `ld_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered |
| st_ready_o | output | 1 | Store accepted this cycle if valid |
| st_addr_i | input | 29 | Store doubleword address |
| st_be_i | input | 8 | Store byte-lane mask |
| st_data_i | input | 64 | Store data |
| ld_valid_i | input | 1 | Load presented |
| ld_ready_o | output | 1 | Load result valid this cycle |
| ld_addr_i | input | 29 | Load doubleword address |
| ld_be_i | input | 8 | Load byte-lane mask |
| ld_data_o | output | 64 | Merged load data |
| ld_fwd_o | output | 8 | Lanes taken from the queue |
| mem_rd_addr_o | output | 29 | Memory read address for the load |
| mem_rd_data_i | input | 64 | Memory read data |
| mem_wr_req_o | output | 1 | Head entry waiting, ownership requested |
| mem_own_i | input | 1 | Target line held writable |
| mem_wr_en_o | output | 1 | Commit head entry this cycle |
| mem_wr_addr_o | output | 29 | Commit address |
| mem_wr_be_o | output | 8 | Commit byte mask |
| mem_wr_data_o | output | 64 | Commit data |
| fence_i | input | 1 | Fence request, held until done |
| fence_done_o | output | 1 | Fence complete |
| lock_i | input | 1 | Locked operation request, held until go |
| lock_go_o | output | 1 | Queue drained, locked operation may run |

## Verification
The bench builds the block with its default depth of 8. At that depth it can fill the queue completely, with two stores to one doubleword among the entries, and so reach the full back-pressure case, youngest-wins lane selection and a full eight-entry drain behind a fence. The eight-entry drain is what shows one commit per cycle in arrival order. Memory is held in a small bench model that applies commits only on the write strobe, so each check of memory content is a check of visibility at commit time.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  localparam int unsigned SB_LANES = 8;
  localparam int unsigned SB_AW    = 29;

  typedef logic [SB_AW-1:0]      dw_addr_t;
  typedef logic [SB_LANES-1:0]   lane_mask_t;
  typedef logic [SB_LANES*8-1:0] dw_data_t;

  typedef struct packed {
    dw_addr_t   addr;
    lane_mask_t be;
    dw_data_t   data;
  } sb_entry_t;
endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue
  import stbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  sb_entry_t                    push_entry_i,
  input  logic                         pop_i,
  output sb_entry_t                    entries_o [DEPTH],
  output logic [$clog2(DEPTH)-1:0]     rd_ptr_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         full_o,
  output sb_entry_t                    head_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  sb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i && !pop_i)      count_q <= count_q + 1'b1;
      else if (pop_i && !push_i) count_q <= count_q - 1'b1;
    end
  end

  // data storage needs no reset: validity comes from the pointers
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr_q == PTR_W'(i)) slot_q[i] <= push_entry_i;
    end
    assign entries_o[i] = slot_q[i];
  end

  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = count_q;
  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign head_o   = slot_q[rd_ptr_q];

  a_r5_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r1_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r9_head_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(rd_ptr_q));
  a_r9_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
  import stbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  sb_entry_t                    entries_i [DEPTH],
  input  logic [$clog2(DEPTH)-1:0]     rd_ptr_i,
  input  logic [$clog2(DEPTH+1)-1:0]   count_i,
  input  dw_addr_t                     ld_addr_i,
  input  lane_mask_t                   ld_be_i,
  input  dw_data_t                     mem_data_i,
  output dw_data_t                     ld_data_o,
  output lane_mask_t                   fwd_mask_o
);
  dw_data_t   buf_data;
  lane_mask_t hit;

  // walk oldest to youngest so later matches overwrite earlier ones
  always_comb begin
    buf_data = '0;
    hit      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int j;
      j = int'(rd_ptr_i) + k;
      if (j >= DEPTH) j = j - DEPTH;
      if (k < int'(count_i) && entries_i[j].addr == ld_addr_i) begin
        for (int b = 0; b < SB_LANES; b++) begin
          if (entries_i[j].be[b] && ld_be_i[b]) begin
            buf_data[b*8 +: 8] = entries_i[j].data[b*8 +: 8];
            hit[b]             = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < SB_LANES; b++) begin
      if (!ld_be_i[b])  ld_data_o[b*8 +: 8] = '0;
      else if (hit[b])  ld_data_o[b*8 +: 8] = buf_data[b*8 +: 8];
      else              ld_data_o[b*8 +: 8] = mem_data_i[b*8 +: 8];
    end
  end

  assign fwd_mask_o = hit;

  a_r11_fwd_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_mask_o & ~ld_be_i) == '0);
  a_r10_empty_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> (fwd_mask_o == '0 && ld_data_o == (mem_data_i & {8{8'hFF}} & ld_data_o)));
endmodule

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fence_i,
  input  logic lock_i,
  input  logic st_valid_i,
  input  logic empty_i,
  input  logic full_i,
  input  logic mem_own_i,
  output logic st_ready_o,
  output logic ld_ready_o,
  output logic fence_done_o,
  output logic lock_go_o,
  output logic push_o,
  output logic pop_o,
  output logic wr_req_o
);
  logic hold;

  // a pending fence or locked op blocks new work; it owns the cycle it completes in
  assign hold         = fence_i | lock_i;
  assign st_ready_o   = !full_i && !hold;
  assign ld_ready_o   = !hold;
  assign fence_done_o = fence_i && empty_i;
  assign lock_go_o    = lock_i && empty_i;
  assign push_o       = st_valid_i && st_ready_o;
  assign wr_req_o     = !empty_i;
  assign pop_o        = wr_req_o && mem_own_i;

  a_r6_fence_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_i && !empty_i) |-> (!fence_done_o && !push_o && !ld_ready_o));
  a_r8_lock_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !empty_i) |-> (!lock_go_o && !push_o && !ld_ready_o));
  a_r6_done_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_i && pop_o && $past(fence_i) && !push_o) |=> (fence_i |-> (fence_done_o == empty_i)));
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   st_valid_i,
  output logic                   st_ready_o,
  input  logic [SB_AW-1:0]       st_addr_i,
  input  logic [SB_LANES-1:0]    st_be_i,
  input  logic [SB_LANES*8-1:0]  st_data_i,
  input  logic                   ld_valid_i,
  output logic                   ld_ready_o,
  input  logic [SB_AW-1:0]       ld_addr_i,
  input  logic [SB_LANES-1:0]    ld_be_i,
  output logic [SB_LANES*8-1:0]  ld_data_o,
  output logic [SB_LANES-1:0]    ld_fwd_o,
  output logic [SB_AW-1:0]       mem_rd_addr_o,
  input  logic [SB_LANES*8-1:0]  mem_rd_data_i,
  output logic                   mem_wr_req_o,
  input  logic                   mem_own_i,
  output logic                   mem_wr_en_o,
  output logic [SB_AW-1:0]       mem_wr_addr_o,
  output logic [SB_LANES-1:0]    mem_wr_be_o,
  output logic [SB_LANES*8-1:0]  mem_wr_data_o,
  input  logic                   fence_i,
  output logic                   fence_done_o,
  input  logic                   lock_i,
  output logic                   lock_go_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  sb_entry_t        entries [DEPTH];
  sb_entry_t        head, new_entry;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             empty, full, push, pop;
  logic             ld_unused;

  assign new_entry = '{addr: st_addr_i, be: st_be_i, data: st_data_i};
  assign ld_unused = ld_valid_i;

  stbuf_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fence_i      (fence_i),
    .lock_i       (lock_i),
    .st_valid_i   (st_valid_i),
    .empty_i      (empty),
    .full_i       (full),
    .mem_own_i    (mem_own_i),
    .st_ready_o   (st_ready_o),
    .ld_ready_o   (ld_ready_o),
    .fence_done_o (fence_done_o),
    .lock_go_o    (lock_go_o),
    .push_o       (push),
    .pop_o        (pop),
    .wr_req_o     (mem_wr_req_o)
  );

  stbuf_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_entry_i (new_entry),
    .pop_i        (pop),
    .entries_o    (entries),
    .rd_ptr_o     (rd_ptr),
    .count_o      (count),
    .empty_o      (empty),
    .full_o       (full),
    .head_o       (head)
  );

  stbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entries_i  (entries),
    .rd_ptr_i   (rd_ptr),
    .count_i    (count),
    .ld_addr_i  (ld_addr_i),
    .ld_be_i    (ld_be_i),
    .mem_data_i (mem_rd_data_i),
    .ld_data_o  (ld_data_o),
    .fwd_mask_o (ld_fwd_o)
  );

  assign mem_rd_addr_o = ld_addr_i;
  assign mem_wr_en_o   = pop;
  assign mem_wr_addr_o = head.addr;
  assign mem_wr_be_o   = head.be;
  assign mem_wr_data_o = head.data;

  a_r1_commit_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_req_o && !mem_own_i) |=> ($stable(rd_ptr) && mem_wr_req_o));
  a_r12_reset_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !mem_wr_req_o);
endmodule

// File: tb/stbuf_top_bench.sv
module stbuf_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 0, ld_valid_i = 0, mem_own_i = 0, fence_i = 0, lock_i = 0;
  logic [28:0] st_addr_i = '0, ld_addr_i = '0;
  logic [7:0]  st_be_i = '0, ld_be_i = '0;
  logic [63:0] st_data_i = '0;
  logic        st_ready_o, ld_ready_o, mem_wr_req_o, mem_wr_en_o, fence_done_o, lock_go_o;
  logic [63:0] ld_data_o, mem_rd_data_i, mem_wr_data_o;
  logic [7:0]  ld_fwd_o, mem_wr_be_o;
  logic [28:0] mem_rd_addr_o, mem_wr_addr_o;

  logic [63:0] mem [16];
  logic [28:0] log_addr [32];
  int          n_log = 0;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #5 clk_i = ~clk_i;

  stbuf_top u_stbuf_top (.*);

  assign mem_rd_data_i = mem[mem_rd_addr_o[3:0]];

  always @(posedge clk_i) begin
    if (mem_wr_en_o) begin
      for (int b = 0; b < 8; b++)
        if (mem_wr_be_o[b]) mem[mem_wr_addr_o[3:0]][b*8 +: 8] <= mem_wr_data_o[b*8 +: 8];
      if (n_log < 32) log_addr[n_log] <= mem_wr_addr_o;
      n_log <= n_log + 1;
    end
  end

  function automatic logic [63:0] init_word(input int i);
    return {8{8'(8'hA0 + i)}};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_store(input int a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk_i);
    st_valid_i = 1; st_addr_i = 29'(a); st_be_i = be; st_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    st_valid_i = 0;
  endtask

  task automatic load(input int a, input logic [7:0] be);
    @(negedge clk_i);
    ld_valid_i = 1; ld_addr_i = 29'(a); ld_be_i = be;
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk_i); #1;
    check("R12 st_ready", 64'(st_ready_o), 64'd1);
    check("R12 ld_ready", 64'(ld_ready_o), 64'd1);
    check("R12 wr_req", 64'(mem_wr_req_o), 64'd0);
  endtask

  task automatic t_hold;
    push_store(2, 8'hFF, 64'h0123_4567_89AB_CDEF);
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 wr_req held", 64'(mem_wr_req_o), 64'd1);
    check("R1 no commit", 64'(n_log), 64'd0);
    check("R1 mem unchanged", mem[2], init_word(2));
  endtask

  task automatic t_exact;
    load(2, 8'hFF);
    check("R2 data", ld_data_o, 64'h0123_4567_89AB_CDEF);
    check("R2 fwd", 64'(ld_fwd_o), 64'hFF);
  endtask

  task automatic t_partial;
    logic [63:0] exp;
    push_store(3, 8'h02, 64'h0000_0000_0000_5A00);
    load(3, 8'hFF);
    exp = init_word(3);
    exp[15:8] = 8'h5A;
    check("R3 merged", ld_data_o, exp);
    check("R3 fwd", 64'(ld_fwd_o), 64'h02);
    check("R3 mem unchanged", mem[3], init_word(3));
    check("R3 still queued", 64'(mem_wr_req_o), 64'd1);
  endtask

  task automatic t_young;
    logic [63:0] exp;
    push_store(4, 8'h0F, 64'h0000_0000_1122_3344);
    push_store(4, 8'h03, 64'h0000_0000_0000_BEEF);
    load(4, 8'h0F);
    check("R4 youngest", ld_data_o, 64'h0000_0000_1122_BEEF);
    check("R4 fwd", 64'(ld_fwd_o), 64'h0F);
    load(4, 8'h30);
    exp = init_word(4) & 64'h0000_FFFF_0000_0000;
    check("R11 lanes off zero", ld_data_o, exp);
    check("R11 fwd in mask", 64'(ld_fwd_o), 64'h00);
  endtask

  task automatic t_nomatch;
    load(9, 8'hFF);
    check("R10 mem data", ld_data_o, init_word(9));
    check("R10 fwd zero", 64'(ld_fwd_o), 64'h00);
    ld_valid_i = 0;
  endtask

  task automatic t_full;
    for (int a = 5; a <= 8; a++) push_store(a, 8'hFF, {8{8'(a)}});
    #1;
    check("R5 not ready", 64'(st_ready_o), 64'd0);
    push_store(10, 8'hFF, 64'hDEAD);
  endtask

  task automatic t_fence;
    int n;
    int exp_a [8] = '{2, 3, 4, 4, 5, 6, 7, 8};
    @(negedge clk_i);
    fence_i = 1;
    #1;
    check("R6 done low", 64'(fence_done_o), 64'd0);
    check("R6 st held", 64'(st_ready_o), 64'd0);
    check("R6 ld held", 64'(ld_ready_o), 64'd0);
    mem_own_i = 1;
    n = 0;
    while (!fence_done_o && n < 20) begin
      @(negedge clk_i); #1; n++;
    end
    check("R6 done", 64'(fence_done_o), 64'd1);
    check("R9 one per cycle", 64'(n), 64'd8);
    check("R9 commit count", 64'(n_log), 64'd8);
    for (int i = 0; i < 8; i++) check("R9 order", 64'(log_addr[i]), 64'(exp_a[i]));
    check("R1 visible", mem[2], 64'h0123_4567_89AB_CDEF);
    check("R4 final", mem[4], {init_word(4)[63:32], 32'h1122_BEEF});
    check("R5 rejected", mem[10], init_word(10));
    fence_i = 0;
  endtask

  task automatic t_fence_empty;
    @(negedge clk_i);
    fence_i = 1;
    #1;
    check("R7 done same cycle", 64'(fence_done_o), 64'd1);
    fence_i = 0;
  endtask

  task automatic t_lock;
    mem_own_i = 0;
    push_store(11, 8'h01, 64'h77);
    lock_i = 1;
    #1;
    check("R8 go low", 64'(lock_go_o), 64'd0);
    check("R8 ld held", 64'(ld_ready_o), 64'd0);
    mem_own_i = 1;
    @(negedge clk_i); #1;
    check("R8 go", 64'(lock_go_o), 64'd1);
    check("R8 drained", mem[11][7:0], 64'h77);
    lock_i = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = init_word(i);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    t_reset;
    t_hold;
    t_exact;
    t_partial;
    t_young;
    t_nomatch;
    t_full;
    t_fence;
    t_fence_empty;
    t_lock;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule